// File: doc/BRIEF.md
# Periodic Countdown Timer Channel

A single general-purpose timer channel with a small 32-bit register interface. Software loads a preset value and turns the channel on. The count then drops by one on each strobe from a selectable time base, for example a one-microsecond tick. When the count runs out, the channel sets a sticky interrupt flag and raises a one-cycle expiry strobe that a neighbouring watchdog can use as its time source.

In periodic mode the channel reloads the preset and keeps running. In one-shot mode it turns itself off. Software clears the flag by writing a one to its status bit. A write to the control register that sets the enable bit always restarts the count from the newly written preset. Tick generation, decoding across several channels and interrupt routing are handled outside this block.

Top module: `pcd_timer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `expire` is low.
- R2: Control register at offset 0x0 has these fields: bit 31 is enable, bit 30 is periodic mode, bits 27:0 are the preset. Bits 29:28 read as zero. Any control write with bit 31 set loads the count from the written preset, and this includes a write while the channel is already running.
- R3: Source select register at offset 0x8 holds the tick index in bits 1:0, and value 0 selects `tick_src[0]`, the microsecond tick. While enabled, the count drops by one only on a strobe of the selected input. Strobes on other inputs are ignored.
- R4: A selected tick that arrives while the count is 1 or 0 is an expiry. On the clock edge that samples it, the flag sets, and `expire` is high for exactly the following cycle. A preset of 0 therefore expires on the first tick.
- R5: In periodic mode, an expiry reloads the count from the preset and the channel stays enabled.
- R6: In one-shot mode, an expiry clears the enable bit and leaves the count at 0. Later ticks then cause no further expiry.
- R7: The status register at offset 0x4 reads the interrupt flag in bit 30 and the current count in bits 27:0. `irq` follows the flag.
- R8: Writing 1 to status bit 30 clears the flag. Writing 0 there has no effect.
- R9: When an expiry and a flag-clearing status write fall in the same cycle, the flag stays set.
- R10: A control write with bit 31 clear stops the channel. The count then holds, and ticks produce no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | NSRC | Time-base strobes, one cycle each; index 0 is the microsecond tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Sticky interrupt flag |
| expire | output | 1 | One-cycle strobe on each expiry |

## Verification
The count is driven with presets of 3, 2, 1 and 0, in both one-shot and periodic mode. This separates the reload path from the self-disable path and shows where the last tick falls. Strobes arrive on a non-selected input and then on a reselected one, which shows whether the source multiplexer gates the decrement. Ticks are sent while the channel is stopped, and the control register is rewritten in the middle of a count, to show that the count holds and that a rewrite reloads it. One cycle carries both an expiry and a clear, to confirm which of the two wins.

// File: rtl/pcd_timer.sv
module pcd_timer #(
  parameter int PRE_W = 28,
  parameter int NSRC  = 4,
  parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  tick_src,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq,
  output logic             expire
);
  localparam logic [3:0] OFS_CTL = 4'h0;
  localparam logic [3:0] OFS_STS = 4'h4;
  localparam logic [3:0] OFS_SRC = 4'h8;
  localparam int         B_EN    = 31;
  localparam int         B_PER   = 30;
  localparam int         B_FLAG  = 30;

  logic             en_q, per_q, flag_q, exp_q;
  logic [PRE_W-1:0] pre_q, cnt_q;
  logic [SEL_W-1:0] src_q;

  logic wr_ctl, wr_sts, wr_src, tick_sel, hit, fire;

  assign wr_ctl   = reg_wr && (reg_addr == OFS_CTL);
  assign wr_sts   = reg_wr && (reg_addr == OFS_STS);
  assign wr_src   = reg_wr && (reg_addr == OFS_SRC);
  assign tick_sel = (int'(src_q) < NSRC) ? tick_src[src_q] : 1'b0;
  assign hit      = en_q && tick_sel && !wr_ctl;
  assign fire     = hit && (cnt_q <= PRE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      src_q  <= '0;
      flag_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= fire;
      if (wr_src) src_q <= reg_wdata[SEL_W-1:0];
      if (wr_ctl) begin
        en_q  <= reg_wdata[B_EN];
        per_q <= reg_wdata[B_PER];
        pre_q <= reg_wdata[PRE_W-1:0];
        if (reg_wdata[B_EN]) cnt_q <= reg_wdata[PRE_W-1:0];
      end else if (fire) begin
        if (per_q) cnt_q <= pre_q;
        else begin
          cnt_q <= '0;
          en_q  <= 1'b0;
        end
      end else if (hit) begin
        cnt_q <= cnt_q - PRE_W'(1);
      end
      if (fire)                            flag_q <= 1'b1;
      else if (wr_sts && reg_wdata[B_FLAG]) flag_q <= 1'b0;
    end
  end

  logic [27:0] pre_ext, cnt_ext;
  assign pre_ext = 28'(pre_q);
  assign cnt_ext = 28'(cnt_q);

  always_comb begin
    case (reg_addr)
      OFS_CTL: reg_rdata = {en_q, per_q, 2'b00, pre_ext};
      OFS_STS: reg_rdata = {1'b0, flag_q, 2'b00, cnt_ext};
      OFS_SRC: reg_rdata = 32'(src_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq    = flag_q;
  assign expire = exp_q;

  initial begin
    assert (PRE_W >= 1 && PRE_W <= 28) else $error("PRE_W out of range");
  end

  a_r4_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> irq);
  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per_q) |-> (cnt_q == pre_q && en_q));
  a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per_q) |-> (!en_q && cnt_q == '0));
  a_r2_count_within_preset: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (cnt_q <= pre_q));
  a_r10_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_ctl) |=> ($stable(cnt_q) && !expire));
endmodule

// File: tb/pcd_timer_bench.sv
module pcd_timer_bench;
  localparam int CLK_P = 10;
  localparam int NSRC  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] tick_src = '0;
  logic            reg_wr = 1'b0;
  logic [3:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq, expire;

  int total = 0;
  int bad = 0;
  int npulse = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pcd_timer #(.PRE_W(28), .NSRC(NSRC)) u_pcd_timer (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .expire(expire)
  );

  always @(negedge clk) if (expire) npulse++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_src = '0; tick_src[idx] = 1'b1;
      @(negedge clk);
      tick_src = '0;
      #1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 ctl", d, 0);
    rd(4'h4, d); chk("R1 sts", d, 0);
    rd(4'h8, d); chk("R1 src", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 expire", {31'b0, expire}, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    int p0;
    wr(4'h0, 32'h8000_0003);
    rd(4'h0, d); chk("R2 ctl readback", d, 32'h8000_0003);
    rd(4'h4, d); chk("R2 load", d, 3);
    p0 = npulse;
    tick(0, 2);
    rd(4'h4, d); chk("R3 decrement", d, 1);
    chk("R4 no early irq", {31'b0, irq}, 0);
    tick(0, 1);
    chk("R4 expire pulse", npulse - p0, 1);
    chk("R4 irq", {31'b0, irq}, 1);
    rd(4'h4, d); chk("R7 status", d, 32'h4000_0000);
    rd(4'h0, d); chk("R6 enable cleared", d, 32'h0000_0003);
    tick(0, 3);
    chk("R6 no more expiry", npulse - p0, 1);
  endtask

  task automatic t_clear();
    wr(4'h4, 32'h0);
    chk("R8 write zero keeps flag", {31'b0, irq}, 1);
    wr(4'h4, 32'h4000_0000);
    chk("R8 w1c clears", {31'b0, irq}, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    int p0;
    p0 = npulse;
    wr(4'h0, 32'hC000_0002);
    tick(0, 4);
    chk("R5 two expiries", npulse - p0, 2);
    rd(4'h4, d); chk("R5 reloaded", d, 32'h4000_0002);
    rd(4'h0, d); chk("R5 still enabled", d, 32'hC000_0002);
    wr(4'h4, 32'h4000_0000);
  endtask

  task automatic t_source();
    logic [31:0] d;
    wr(4'h0, 32'hC000_0005);
    tick(1, 2);
    rd(4'h4, d); chk("R3 other source ignored", d, 5);
    wr(4'h8, 32'h1);
    rd(4'h8, d); chk("R3 select readback", d, 1);
    tick(1, 2);
    rd(4'h4, d); chk("R3 selected source counts", d, 3);
    tick(0, 1);
    rd(4'h4, d); chk("R3 tick0 now ignored", d, 3);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_rewrite_stop();
    logic [31:0] d;
    int p0;
    wr(4'h0, 32'h8000_0007);
    rd(4'h4, d); chk("R2 rewrite reloads", d, 7);
    tick(0, 2);
    wr(4'h0, 32'h0);
    p0 = npulse;
    tick(0, 6);
    rd(4'h4, d); chk("R10 count holds", d, 5);
    chk("R10 no expiry", npulse - p0, 0);
  endtask

  task automatic t_race_and_zero();
    int p0;
    wr(4'h0, 32'hC000_0001);
    p0 = npulse;
    @(negedge clk);
    tick_src = 4'b0001;
    reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h4000_0000;
    @(negedge clk);
    tick_src = '0; reg_wr = 1'b0;
    #1;
    chk("R9 expiry beats clear", {31'b0, irq}, 1);
    chk("R9 pulse", npulse - p0, 1);
    wr(4'h4, 32'h4000_0000);
    wr(4'h0, 32'h8000_0000);
    p0 = npulse;
    tick(0, 1);
    chk("R4 preset zero expires", npulse - p0, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_oneshot();
    t_clear();
    t_periodic();
    t_source();
    t_rewrite_stop();
    t_race_and_zero();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule